// File: doc/BRIEF.md
# Two-Channel Volume Mixer with Rate-Family Lock

This block is the mixing stage of a two-voice playback path. Each cycle in which `in_valid` is high it takes one signed sample from each voice. It scales each sample by that voice's own logarithmic volume and adds the two results. The sum is then clamped to a 14-bit signed output word. The registered word appears one cycle later together with `out_valid`, and `sat_pulse` marks each word that had to be clamped. A voice whose `ch_active` bit is low adds nothing to the sum.

The same block decides which output sample-rate family is in force. Every rate request is a 4-bit code: bits [3:2] give the family and bits [1:0] give the octave multiplier. Family 0 is the 4 kHz series (4, 8, 16, 32 kHz), family 1 is the 5.3 kHz series (5.3, 10.7, 21.3, 42.7 kHz) and family 2 is the 6.4 kHz series (6.4, 12.8, 25.6 kHz). Family code 3 is reserved.

A small state machine decides which voice owns the family. Its states are `ST_IDLE` (no voice playing), `ST_OWN0` (voice 0 owns the family) and `ST_OWN1` (voice 1 owns it). It has five transitions:
- T_START0: IDLE to OWN0 when voice 0 is active; voice 0 wins a tie.
- T_START1: IDLE to OWN1 when only voice 1 is active.
- T_HAND01: OWN0 to OWN1 when voice 0 stops and voice 1 still plays.
- T_HAND10: OWN1 to OWN0, the mirror of T_HAND01.
- T_STOP: OWN0 or OWN1 to IDLE when no voice remains active.

On T_START and T_HAND the family field of the new owner's request is latched. On T_STOP the latched family returns to 0. The owner keeps the latched family for as long as it plays.

Top module: `mix2ch_vol_sat`

## Requirements
- R1: Each voice with volume code v (0..28) is scaled as follows.
  - The attenuation in dB is A = 2v for v ≤ 15, and A = 30 + 5(v−15) for v > 15.
  - With e = A/6 and r = A mod 6, the mantissa m is taken from r = 0..5 as 256, 228, 203, 181, 162, 144.
  - The scaled value is (sample·m) arithmetically shifted right by 8+e.
- R2: Volume codes 29, 30 and 31 scale exactly like code 28.
- R3: A voice whose `ch_active` bit is low contributes zero to the sum, whatever its sample and volume.
- R4: The sum of the two scaled values is clamped to [−2^(OUT_W−1), 2^(OUT_W−1)−1], that is [−8192, 8191] by default, and otherwise passed unchanged.
- R5: `out_valid` is `in_valid` delayed by one clock. `out_sample` is loaded only in that cycle and holds its value otherwise.
- R6: `sat_pulse` is high for exactly the output cycles whose word was clamped.
- R7: After reset, `out_sample`, `out_valid`, `sat_pulse`, `rate_locked` and `rate_fam` are all zero.
- R8: The first voice to become active locks the family to its own request; voice 0 wins a tie. When no voice is active the lock is released (`rate_locked` = 0, `rate_fam` = 0).
- R9: While the family is locked, each active voice has effective rate {`rate_fam`, own octave}. `rate_mismatch` is high when any active voice requests a different family.
- R10: While unlocked, and for any inactive voice, the effective rate equals the requested rate, and `rate_mismatch` is 0.
- R11: When the owner stops while the other voice still plays, the other voice takes ownership and the family becomes that voice's own requested family.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New input sample pair strobe |
| in_smp0 | input | IN_W | Voice 0 signed sample |
| in_smp1 | input | IN_W | Voice 1 signed sample |
| vol0 | input | 5 | Voice 0 volume code |
| vol1 | input | 5 | Voice 1 volume code |
| ch_active | input | 2 | Per-voice playing flags, bit 0 = voice 0 |
| req_rate0 | input | 4 | Voice 0 requested rate code |
| req_rate1 | input | 4 | Voice 1 requested rate code |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | OUT_W | Mixed, clamped signed sample |
| sat_pulse | output | 1 | Clamping occurred on this output |
| rate_locked | output | 1 | A family is in force |
| rate_fam | output | 2 | Latched family code |
| eff_rate0 | output | 4 | Voice 0 effective rate code |
| eff_rate1 | output | 4 | Voice 1 effective rate code |
| rate_mismatch | output | 1 | An active voice asked for another family |

## Verification
The bench builds the block at its defaults, IN_W = 16 and OUT_W = 14. With these values a single voice at 0 dB already exceeds the output range, so clamping at both rails can be reached from one voice alone as well as from the sum of two. The bench sweeps all 32 volume codes on both voices against extreme and small sample pairs, which covers every attenuation step and the codes above 28. For the rate logic it walks every family and octave request of the second voice against a locked family, then exercises the tie, hand-over and release sequences.

// File: rtl/mix_pkg.sv
package mix_pkg;

    localparam int VOL_W  = 5;
    localparam int VOL_MAX = 28;
    localparam int MANT_W = 9;
    localparam int FRAC   = 8;
    localparam int FAM_W  = 2;
    localparam int OCT_W  = 2;
    localparam int RATE_W = FAM_W + OCT_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OWN0 = 2'd1,
        ST_OWN1 = 2'd2
    } arb_state_t;

    // attenuation in dB for a volume code
    function automatic int atten_db(input logic [VOL_W-1:0] v);
        int a;
        a = (int'(v) > VOL_MAX) ? VOL_MAX : int'(v);
        return (a <= 15) ? 2 * a : 30 + 5 * (a - 15);
    endfunction

    function automatic logic [3:0] gain_shift(input logic [VOL_W-1:0] v);
        return 4'(atten_db(v) / 6);
    endfunction

    function automatic logic [MANT_W-1:0] gain_mant(input logic [VOL_W-1:0] v);
        case (atten_db(v) % 6)
            0:       return 9'd256;
            1:       return 9'd228;
            2:       return 9'd203;
            3:       return 9'd181;
            4:       return 9'd162;
            default: return 9'd144;
        endcase
    endfunction

endpackage

// File: rtl/mix_gain.sv
module mix_gain
    import mix_pkg::*;
#(
    parameter int IN_W = 16
) (
    input  logic                    en,
    input  logic signed [IN_W-1:0]  smp,
    input  logic [VOL_W-1:0]        vol,
    output logic signed [IN_W-1:0]  scaled
);
    localparam int ACC_W = IN_W + MANT_W + 1;

    logic [MANT_W-1:0]        mant;
    logic [3:0]               shft;
    logic signed [ACC_W-1:0]  xe;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  shd;

    assign mant = gain_mant(vol);
    assign shft = gain_shift(vol);

    // shift-and-add product, then the octave shift
    always_comb begin
        xe  = en ? ACC_W'(smp) : '0;
        acc = '0;
        for (int b = 0; b < MANT_W; b++) begin
            if (mant[b]) acc = acc + (xe <<< b);
        end
        shd    = acc >>> (FRAC + int'(shft));
        scaled = shd[IN_W-1:0];
    end

endmodule

// File: rtl/mix_clamp.sv
module mix_clamp #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 14
) (
    input  logic signed [IN_W-1:0]  a,
    input  logic signed [IN_W-1:0]  b,
    output logic [OUT_W-1:0]        y,
    output logic                    clipped
);
    localparam int SUM_W = IN_W + 1;
    localparam logic signed [SUM_W-1:0] HI = SUM_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] LO = -HI - SUM_W'(1);

    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum = SUM_W'(a) + SUM_W'(b);
        if (sum > HI) begin
            y       = HI[OUT_W-1:0];
            clipped = 1'b1;
        end else if (sum < LO) begin
            y       = LO[OUT_W-1:0];
            clipped = 1'b1;
        end else begin
            y       = sum[OUT_W-1:0];
            clipped = 1'b0;
        end
    end

endmodule

// File: rtl/mix_rate_arb.sv
module mix_rate_arb
    import mix_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        act,
    input  logic [RATE_W-1:0] req0,
    input  logic [RATE_W-1:0] req1,
    output logic              locked,
    output logic [FAM_W-1:0]  fam,
    output logic [RATE_W-1:0] eff0,
    output logic [RATE_W-1:0] eff1,
    output logic              mismatch
);
    arb_state_t        state_q, state_d;
    logic [FAM_W-1:0]  fam_q, fam_d;

    always_comb begin
        state_d = state_q;
        fam_d   = fam_q;
        unique case (state_q)
            ST_IDLE: begin
                if (act[0]) begin                 // T_START0
                    state_d = ST_OWN0;
                    fam_d   = req0[RATE_W-1:OCT_W];
                end else if (act[1]) begin        // T_START1
                    state_d = ST_OWN1;
                    fam_d   = req1[RATE_W-1:OCT_W];
                end
            end
            ST_OWN0: begin
                if (!act[0]) begin
                    if (act[1]) begin             // T_HAND01
                        state_d = ST_OWN1;
                        fam_d   = req1[RATE_W-1:OCT_W];
                    end else begin                // T_STOP
                        state_d = ST_IDLE;
                        fam_d   = '0;
                    end
                end
            end
            ST_OWN1: begin
                if (!act[1]) begin
                    if (act[0]) begin             // T_HAND10
                        state_d = ST_OWN0;
                        fam_d   = req0[RATE_W-1:OCT_W];
                    end else begin                // T_STOP
                        state_d = ST_IDLE;
                        fam_d   = '0;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                fam_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fam_q   <= '0;
        end else begin
            state_q <= state_d;
            fam_q   <= fam_d;
        end
    end

    always_comb begin
        locked = (state_q != ST_IDLE);
        fam    = fam_q;
        eff0   = req0;
        eff1   = req1;
        mismatch = 1'b0;
        if (locked && act[0]) begin
            eff0 = {fam_q, req0[OCT_W-1:0]};
            if (req0[RATE_W-1:OCT_W] != fam_q) mismatch = 1'b1;
        end
        if (locked && act[1]) begin
            eff1 = {fam_q, req1[OCT_W-1:0]};
            if (req1[RATE_W-1:OCT_W] != fam_q) mismatch = 1'b1;
        end
    end

endmodule

// File: rtl/mix2ch_vol_sat.sv
module mix2ch_vol_sat
    import mix_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_smp0,
    input  logic signed [IN_W-1:0]  in_smp1,
    input  logic [VOL_W-1:0]        vol0,
    input  logic [VOL_W-1:0]        vol1,
    input  logic [1:0]              ch_active,
    input  logic [RATE_W-1:0]       req_rate0,
    input  logic [RATE_W-1:0]       req_rate1,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        out_sample,
    output logic                    sat_pulse,
    output logic                    rate_locked,
    output logic [FAM_W-1:0]        rate_fam,
    output logic [RATE_W-1:0]       eff_rate0,
    output logic [RATE_W-1:0]       eff_rate1,
    output logic                    rate_mismatch
);
    logic signed [IN_W-1:0]  smp  [2];
    logic [VOL_W-1:0]        vol  [2];
    logic signed [IN_W-1:0]  scl  [2];
    logic [OUT_W-1:0]        mix_y;
    logic                    mix_clip;

    assign smp[0] = in_smp0;
    assign smp[1] = in_smp1;
    assign vol[0] = vol0;
    assign vol[1] = vol1;

    for (genvar c = 0; c < 2; c++) begin : g_ch
        mix_gain #(.IN_W(IN_W)) i_gain (
            .en     (ch_active[c]),
            .smp    (smp[c]),
            .vol    (vol[c]),
            .scaled (scl[c])
        );
    end

    mix_clamp #(.IN_W(IN_W), .OUT_W(OUT_W)) i_clamp (
        .a       (scl[0]),
        .b       (scl[1]),
        .y       (mix_y),
        .clipped (mix_clip)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
            sat_pulse  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            sat_pulse <= in_valid & mix_clip;
            if (in_valid) out_sample <= mix_y;
        end
    end

    mix_rate_arb i_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (ch_active),
        .req0     (req_rate0),
        .req1     (req_rate1),
        .locked   (rate_locked),
        .fam      (rate_fam),
        .eff0     (eff_rate0),
        .eff1     (eff_rate1),
        .mismatch (rate_mismatch)
    );

endmodule

// File: rtl/mix2ch_checker.sv
module mix2ch_checker #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        ch_active,
    input logic              out_valid,
    input logic [OUT_W-1:0]  out_sample,
    input logic              sat_pulse,
    input logic              rate_locked,
    input logic [1:0]        rate_fam,
    input logic              rate_mismatch
);
    localparam logic [OUT_W-1:0] FS_HI = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] FS_LO = {1'b1, {(OUT_W-1){1'b0}}};

    AST_STROBE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R5
    AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R5
    AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample)); // R5
    AST_SAT_FULLSCALE: assert property (@(posedge clk) disable iff (!rst_n)
        sat_pulse |-> (out_sample == FS_HI || out_sample == FS_LO)); // R4
    AST_SAT_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        sat_pulse |-> out_valid); // R6
    AST_IDLE_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ch_active) == 2'b00) |-> !rate_locked); // R8
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rate_locked) && $past(ch_active) == 2'b11) |-> $stable(rate_fam)); // R8
    AST_MISMATCH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        rate_mismatch |-> rate_locked); // R9

endmodule

bind mix2ch_vol_sat mix2ch_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) i_chk (.*);

// File: tb/test_mix2ch_vol_sat.sv
module test_mix2ch_vol_sat;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W  = 16;
    localparam int OUT_W = 14;
    localparam int HI = (2 ** (OUT_W - 1)) - 1;
    localparam int LO = -(2 ** (OUT_W - 1));

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic signed [IN_W-1:0] in_smp0 = '0;
    logic signed [IN_W-1:0] in_smp1 = '0;
    logic [4:0]             vol0 = '0;
    logic [4:0]             vol1 = '0;
    logic [1:0]             ch_active = '0;
    logic [3:0]             req_rate0 = '0;
    logic [3:0]             req_rate1 = '0;
    logic                   out_valid;
    logic [OUT_W-1:0]       out_sample;
    logic                   sat_pulse;
    logic                   rate_locked;
    logic [1:0]             rate_fam;
    logic [3:0]             eff_rate0;
    logic [3:0]             eff_rate1;
    logic                   rate_mismatch;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mix2ch_vol_sat #(.IN_W(IN_W), .OUT_W(OUT_W)) i_mix2ch_vol_sat (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int scale(input int s, input int v);
        int a, att, e, m;
        a   = (v > 28) ? 28 : v;
        att = (a <= 15) ? 2 * a : 30 + 5 * (a - 15);
        e   = att / 6;
        case (att % 6)
            0: m = 256;
            1: m = 228;
            2: m = 203;
            3: m = 181;
            4: m = 162;
            default: m = 144;
        endcase
        return (s * m) >>> (8 + e);
    endfunction

    function automatic int out_s();
        return int'($signed(out_sample));
    endfunction

    // drive one sample pair and check the word one cycle later
    task automatic mix_vec(input int s0, input int s1, input int v0, input int v1,
                           input logic [1:0] act, input string tag);
        int sum, exp;
        bit clip;
        in_valid  = 1'b1;
        in_smp0   = IN_W'(s0);
        in_smp1   = IN_W'(s1);
        vol0      = 5'(v0);
        vol1      = 5'(v1);
        ch_active = act;
        sum = (act[0] ? scale(s0, v0) : 0) + (act[1] ? scale(s1, v1) : 0);
        clip = (sum > HI) || (sum < LO);
        exp  = (sum > HI) ? HI : (sum < LO) ? LO : sum;
        step();
        chk({tag, " R4 sample"}, out_s(), exp);
        chk("R5 strobe", int'(out_valid), 1);
        chk("R6 sat", int'(sat_pulse), int'(clip));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        int pat0 [6] = '{32767, -32768, 12345, -7, 1000, -20000};
        int pat1 [6] = '{32767, -32768, -12345, 9, 30000, 5};
        int held;
        repeat (3) @(negedge clk);
        // R7: reset state
        chk("R7 out_sample", out_s(), 0);
        chk("R7 out_valid", int'(out_valid), 0);
        chk("R7 sat", int'(sat_pulse), 0);
        chk("R7 locked", int'(rate_locked), 0);
        chk("R7 fam", int'(rate_fam), 0);
        rst_n = 1'b1;
        step();

        // R1 R2 R4 R6: full volume sweep on both voices
        for (int v0 = 0; v0 < 32; v0++) begin
            for (int v1 = 0; v1 < 32; v1++) begin
                for (int p = 0; p < 6; p++) begin
                    mix_vec(pat0[p], pat1[p], v0, v1, 2'b11, "R1 R2");
                end
            end
        end
        // R3: inactive voices add zero
        for (int p = 0; p < 6; p++) begin
            mix_vec(pat0[p], pat1[p], 0, 0, 2'b01, "R3 only0");
            mix_vec(pat0[p], pat1[p], 0, 0, 2'b10, "R3 only1");
            mix_vec(pat0[p], pat1[p], 0, 0, 2'b00, "R3 none");
        end
        // R2: codes above 28 equal code 28 on a large sample
        mix_vec(32767, 0, 31, 0, 2'b01, "R2 code31");
        chk("R2 vs28", out_s(), scale(32767, 28));

        // R5: hold when no strobe
        mix_vec(4000, 0, 0, 0, 2'b01, "R5 load");
        held = out_s();
        in_valid = 1'b0;
        in_smp0  = 16'sd100;
        step();
        chk("R5 quiet strobe", int'(out_valid), 0);
        chk("R5 held sample", out_s(), held);
        chk("R6 quiet sat", int'(sat_pulse), 0);
        ch_active = 2'b00;
        step();
        step();

        // R10: unlocked passes requests through
        req_rate0 = 4'b0110;
        req_rate1 = 4'b1011;
        step();
        chk("R10 locked", int'(rate_locked), 0);
        chk("R10 eff0", int'(eff_rate0), 6);
        chk("R10 eff1", int'(eff_rate1), 11);
        chk("R10 mismatch", int'(rate_mismatch), 0);

        // R8: voice 0 starts with family 1
        req_rate0 = 4'b0101;
        ch_active = 2'b01;
        step();
        chk("R8 locked", int'(rate_locked), 1);
        chk("R8 fam", int'(rate_fam), 1);
        chk("R9 eff0", int'(eff_rate0), 5);

        // R9: every request of voice 1 against family 1
        ch_active = 2'b11;
        for (int f = 0; f < 3; f++) begin
            for (int o = 0; o < 4; o++) begin
                req_rate1 = 4'((f << 2) | o);
                step();
                chk("R9 fam held", int'(rate_fam), 1);
                chk("R9 eff1", int'(eff_rate1), (1 << 2) | o);
                chk("R9 mismatch", int'(rate_mismatch), int'(f != 1));
            end
        end

        // R11: owner stops, voice 1 takes over with its own family
        req_rate1 = 4'b1011;
        ch_active = 2'b10;
        step();
        chk("R11 locked", int'(rate_locked), 1);
        chk("R11 fam", int'(rate_fam), 2);
        chk("R11 eff1", int'(eff_rate1), 11);
        chk("R11 mismatch", int'(rate_mismatch), 0);

        // R8: release
        ch_active = 2'b00;
        step();
        chk("R8 release", int'(rate_locked), 0);
        chk("R8 fam clear", int'(rate_fam), 0);

        // R8: tie from idle, voice 0 wins
        req_rate0 = 4'b0010;
        req_rate1 = 4'b1001;
        ch_active = 2'b11;
        step();
        chk("R8 tie fam", int'(rate_fam), 0);
        chk("R9 tie eff1", int'(eff_rate1), 1);
        chk("R9 tie mismatch", int'(rate_mismatch), 1);
        chk("R9 tie eff0", int'(eff_rate0), 2);

        // R10: inactive voice passes through while locked
        ch_active = 2'b01;
        step();
        chk("R10 inactive eff1", int'(eff_rate1), 9);
        chk("R10 no mismatch", int'(rate_mismatch), 0);

        summary();
    end

endmodule